// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is a test-access data register that lets an external debugger read and write a bank of 32-bit registers over a boundary-scan chain. Each scan carries a 40-bit frame, shifted in least significant bit first. Bits 31:0 hold the data, bits 38:32 hold a 7-bit register address, and bit 39 is the direction flag (1 = write, 0 = read). When the update strobe arrives, the block issues the requested access as a one-cycle request on a simple register bus.

Reads are pipelined. The value that leaves on the serial output during a scan is the result of the read requested by the previous scan. A read with side effects must therefore be followed by a scan to a harmless address. Address 0 is a read-only identification register that the block answers internally. Address 4 is the streaming word port of the attached register space, and every read of it consumes a word. A burst holds address 4 for several scans and ends on address 0, so that no extra word is taken.

The state strobes (capture, shift, update) come from a test-access-port controller running on the same clock. The controller also supplies the flag that tells whether this chain's instruction (code 0xC) is selected. The block assumes the bus returns read data in the same cycle as the request.

Top module: `jtag_regacc_dr`

## Requirements
- R1: After reset, the serial output is 0, no bus request is active, and the held read result is zero, so the first capture shifts out 40 zero bits.
- R2: While selected, each shift cycle moves the frame one place toward bit 0. The serial output during the i-th shift cycle (i from 0) is bit i of the captured frame, and the serial input becomes bit 39 of the frame.
- R3: A capture while selected loads the held read result into frame bits 31:0 and zero into bits 39:32.
- R4: An update while selected, with flag bit 39 = 1 and an address in 1..NUM_REGS-1, raises the request strobe for exactly one cycle with write = 1, address = bits 38:32 and write data = bits 31:0.
- R5: An update while selected, with flag = 0 and an address in 1..NUM_REGS-1, raises exactly one read strobe. The returned bus data is the value captured by the next selected scan.
- R6: Address 0 never raises a strobe. A read of it yields the ID_VALUE parameter in the next scan, and a write to it is ignored.
- R7: Addresses NUM_REGS and above never raise a strobe, and a read of them yields zero in the next scan.
- R8: With the instruction not selected, capture, shift and update have no effect: the frame and the serial output stay constant, no strobe is raised, and the held result is kept for the next selected scan.
- R9: A write scan leaves the held read result unchanged.
- R10: Consecutive read scans of address 4 return successive stream words, one per scan. Ending the burst with a read of address 0 consumes no further word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_sel | input | 1 | This chain's instruction is selected |
| capture_dr | input | 1 | Capture state strobe |
| shift_dr | input | 1 | Shift state strobe |
| update_dr | input | 1 | Update state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| req_valid | output | 1 | One-cycle register bus request |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 7 | Request register address |
| req_wdata | output | 32 | Request write data |
| bus_rdata | input | 32 | Read data, valid in the request cycle |

## Verification
During each shift cycle, two things happen at once: the previous read result leaves on the serial output, and the next request frame enters on the serial input. The bench runs back-to-back scans across every address from 0 to 15, in both directions. Each captured word is compared with an arithmetic model of the previous scan's request, while the strobes of the current scan are counted and their fields compared. A stream burst on address 4 that closes on address 0 tests whether the pipelined read consumes words exactly once.

// File: rtl/jrd_pkg.sv
// Shared frame geometry for the register access data register.
// Assumes a fixed frame: data field low, address above, direction flag on top.
package jrd_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int FLAG_POS = FRAME_W - 1;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/jrd_shift_reg.sv
// Serial frame register: parallel load at capture, LSB-first shift.
// Assumes capture and shift strobes are never asserted together; capture wins.
module jrd_shift_reg #(
    parameter int FRAME_W = 40,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               capture,
    input  logic               shift,
    input  logic               tdi,
    input  logic [DATA_W-1:0]  load_data,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    localparam int HI_W = FRAME_W - DATA_W;

    // Frame register: load held result at capture, shift toward bit 0 otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (sel && capture) begin
            frame <= {{HI_W{1'b0}}, load_data};
        end else if (sel && shift) begin
            frame <= {tdi, frame[FRAME_W-1:1]};
        end
    end

    assign tdo = frame[0];

    // R3
    capture_zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture) |=> (frame[FRAME_W-1:DATA_W] == '0));

    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=> (frame[FRAME_W-2:0] == $past(frame[FRAME_W-1:1])));

    // R8
    unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(frame));
endmodule

// File: rtl/jrd_access.sv
// Turns an updated frame into one bus request and holds the read result.
// Assumes the bus returns read data combinationally in the request cycle,
// and that update strobes are separated by at least one idle cycle.
module jrd_access
    import jrd_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter logic [31:0] ID_VALUE = 32'h4A52_4431
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              update,
    input  frame_t            frame,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] held
);
    localparam int CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NUM_REGS);

    logic   pend;
    frame_t pend_f;
    logic   is_id;
    logic   is_impl;

    // Request stage: latch the frame fields at a selected update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            pend_f <= '0;
        end else if (sel && update) begin
            pend   <= 1'b1;
            pend_f <= frame;
        end else begin
            pend   <= 1'b0;
        end
    end

    assign is_id   = (pend_f.addr == '0);
    assign is_impl = !is_id && ({1'b0, pend_f.addr} < LIMIT);

    assign req_valid = pend && is_impl;
    assign req_write = pend_f.wr;
    assign req_addr  = pend_f.addr;
    assign req_wdata = pend_f.data;

    // Result holder: record the read answer; writes leave it alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (pend && !pend_f.wr) begin
            if (is_id)        held <= ID_VALUE;
            else if (is_impl) held <= bus_rdata;
            else              held <= '0;
        end
    end

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R6
    no_id_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr != '0));

    // R7
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr} < LIMIT));

    // R9
    write_keeps_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> $stable(held));

    // R8
    unselected_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !sel) |=> !req_valid);
endmodule

// File: rtl/jtag_regacc_dr.sv
// Register access data register: 40-bit scan frame to register bus request.
// Assumes the TAP strobes are synchronous enables in the clk domain.
module jtag_regacc_dr
    import jrd_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter logic [31:0] ID_VALUE = 32'h4A52_4431
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [FRAME_W-1:0] frame_bits;
    logic [DATA_W-1:0]  held;

    jrd_shift_reg #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (instr_sel),
        .capture   (capture_dr),
        .shift     (shift_dr),
        .tdi       (tdi),
        .load_data (held),
        .frame     (frame_bits),
        .tdo       (tdo)
    );

    jrd_access #(
        .NUM_REGS (NUM_REGS),
        .ID_VALUE (ID_VALUE)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (instr_sel),
        .update    (update_dr),
        .frame     (frame_t'(frame_bits)),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .held      (held)
    );
endmodule

// File: tb/jtag_regacc_dr_test.sv
module jtag_regacc_dr_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID = 32'h4A52_4431;
    localparam logic [31:0] STREAM_BASE = 32'hC0DE_0000;

    logic clk = 0, rst_n = 0;
    logic instr_sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, req_valid, req_write;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata, bus_rdata;

    int tests = 0, fails = 0;

    jtag_regacc_dr uut (
        .clk(clk), .rst_n(rst_n), .instr_sel(instr_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Environment: small register space with a stream port at address 4
    logic [31:0] env_regs [8];
    int stream_cnt = 0;
    always_comb bus_rdata = (req_addr == 7'd4) ? STREAM_BASE + 32'(stream_cnt)
                                               : env_regs[req_addr[2:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) env_regs[i] <= '0;
            stream_cnt <= 0;
        end else if (req_valid) begin
            if (req_write && req_addr != 7'd4) env_regs[req_addr[2:0]] <= req_wdata;
            if (!req_write && req_addr == 7'd4) stream_cnt <= stream_cnt + 1;
        end
    end

    // Strobe monitor
    int nreq = 0;
    logic lw; logic [6:0] la; logic [31:0] ld;
    always @(negedge clk) if (req_valid) begin
        nreq++; lw = req_write; la = req_addr; ld = req_wdata;
    end

    // Bench model
    logic [31:0] shadow [8];
    logic [31:0] exp_held = '0;
    int exp_sc = 0;
    logic [39:0] last_frame = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic scan(input bit s, input bit w, input logic [6:0] a, input logic [31:0] d,
                        input string tag);
        logic [39:0] fr, cap;
        int n0;
        bit impl;
        fr = {w, a, d};
        n0 = nreq;
        instr_sel = s;
        capture_dr = 1;
        @(negedge clk);
        capture_dr = 0;
        for (int i = 0; i < 40; i++) begin
            cap[i] = tdo;
            tdi = fr[i];
            shift_dr = 1;
            @(negedge clk);
        end
        shift_dr = 0;
        update_dr = 1;
        @(negedge clk);
        update_dr = 0;
        repeat (3) @(negedge clk);
        impl = (a != 0) && (a < 8);
        if (!s) begin
            // R8: unselected scan changes nothing
            check(cap == {40{last_frame[0]}}, {"R8 frame frozen ", tag}, 64'(cap), 64'({40{last_frame[0]}}));
            check(nreq == n0, {"R8 no strobe ", tag}, 64'(nreq - n0), 64'd0);
        end else begin
            // R2/R5/R6/R7/R9/R10: captured result belongs to the previous request
            check(cap[31:0] == exp_held, {"R5 R2 captured result ", tag}, 64'(cap[31:0]), 64'(exp_held));
            // R3
            check(cap[39:32] == 8'h00, {"R3 upper frame zero ", tag}, 64'(cap[39:32]), 64'd0);
            // R4 R6 R7: strobe count
            check(nreq - n0 == (impl ? 1 : 0), {"R4 R6 R7 strobe count ", tag}, 64'(nreq - n0), 64'(impl));
            if (impl && nreq - n0 == 1)
                check(lw == w && la == a && (!w || ld == d), {"R4 request fields ", tag},
                      {31'd0, lw, 7'd0, la, ld}, {31'd0, w, 7'd0, a, d});
            if (w) begin
                if (impl && a != 4) shadow[a[2:0]] = d;
            end else if (a == 0) exp_held = ID;
            else if (!impl) exp_held = '0;
            else if (a == 4) begin exp_held = STREAM_BASE + 32'(exp_sc); exp_sc++; end
            else exp_held = shadow[a[2:0]];
            last_frame = fr;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(tdo == 1'b0 && req_valid == 1'b0, "R1 reset outputs", {62'd0, tdo, req_valid}, 64'd0);
        scan(1, 0, 7'd0, 32'h0, "R1 first capture");
        // writes over addresses 0..15
        for (int a = 0; a < 16; a++)
            scan(1, 1, 7'(a), 32'h1000_0000 + 32'(a) * 32'h0101_0101, "R4 R9 write sweep");
        // R9: the ID read result must survive the write sweep
        // reads over addresses 0..15 (R6 R7 R5)
        for (int a = 0; a < 16; a++) scan(1, 0, 7'(a), 32'hFFFF_FFFF, "R5 R6 R7 read sweep");
        scan(1, 0, 7'd127, 32'h0, "R7 top address");
        // R8: unselected scans between a read and its result
        scan(1, 0, 7'd2, 32'h0, "R8 setup");
        scan(0, 0, 7'd3, 32'h0, "R8 unselected read");
        scan(0, 1, 7'd2, 32'hDEAD_BEEF, "R8 unselected write");
        scan(1, 0, 7'd0, 32'h0, "R8 result kept");
        // R6: write to ID is ignored
        scan(1, 1, 7'd0, 32'h1234_5678, "R6 ID write");
        scan(1, 0, 7'd0, 32'h0, "R6 ID read");
        // R10: stream burst ending on address 0
        for (int k = 0; k < 4; k++) scan(1, 0, 7'd4, 32'h0, "R10 burst");
        scan(1, 0, 7'd0, 32'h0, "R10 burst end");
        scan(1, 0, 7'd0, 32'h0, "R10 drain");
        check(stream_cnt == exp_sc, "R10 words consumed", 64'(stream_cnt), 64'(exp_sc));
        // R9: write after a read keeps the read result
        scan(1, 0, 7'd5, 32'h0, "R9 read");
        scan(1, 1, 7'd6, 32'hA5A5_5A5A, "R9 write");
        scan(1, 0, 7'd6, 32'h0, "R9 after write");
        scan(1, 0, 7'd0, 32'h0, "R9 readback");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule